// File: doc/BRIEF.md
# Register File with Banked Stack Pointer

This block is a sixteen-entry general-purpose register file for a small processor core. The highest-numbered entry, register 15, is the live stack pointer. Behind it sit two holding slots, one for interrupt mode and one for user mode. A status word held next to the file carries a stack-mode flag that selects which slot is tied to the live stack pointer. It also carries an interrupt-enable flag.

Software changes the stack mode by writing the status word through a dedicated port. On that clock edge the block parks the live stack pointer in the slot of the mode being left. Then, if the mode changed, it loads register 15 from the slot of the mode being entered. The core therefore sees one stack pointer register at all times, and each mode keeps its own stack. Two combinational read ports and one write port serve instruction operands. Each read port forwards a same-cycle write to the index it reads.

Top module: `bsp_regfile`

## Requirements
- R1: While `rst_n` is low, all sixteen registers and both holding slots clear to zero, the stack-mode flag becomes 0 (interrupt mode) and the interrupt-enable flag becomes 0.
- R2: When `wr_en` is high, `wr_data` is stored into register `wr_idx` at the rising clock edge. `rd_a_data` and `rd_b_data` combinationally show the registers selected by `rd_a_idx` and `rd_b_idx`.
- R3: When `wr_en` is high and a read index equals `wr_idx`, that read port returns `wr_data` in the same cycle.
- R4: When `st_wr_en` is high, the stack-mode flag takes bit 15 of `st_wr_data` and the interrupt-enable flag takes bit 7. All other bits are ignored. When `st_wr_en` is low, both flags hold.
- R5: On every status write, the value register 15 held before the edge is stored into the slot of the old mode. Slot 0 belongs to interrupt mode (flag 0) and slot 1 to user mode (flag 1).
- R6: On a status write that changes the stack-mode flag, register 15 is loaded at the same edge from the slot of the new mode.
- R7: A status write that leaves the stack-mode flag unchanged leaves register 15 unchanged.
- R8: A general write to register 15 in the same cycle as a status write takes priority over the restored value. The slot save still uses the pre-edge value of register 15.
- R9: The holding slots change only on status writes. General writes to any register, including register 15, leave both slots unchanged, and a swap changes no register other than 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 16 | General register write data |
| st_wr_en | input | 1 | Status word write enable |
| st_wr_data | input | 16 | New status word value |
| stack_mode | output | 1 | Current stack-mode flag (0 interrupt, 1 user) |
| int_en | output | 1 | Current interrupt-enable flag |

## Verification
Several behaviours are checked by assertions on every cycle:
- flag latching and flag hold;
- the save into the old-mode slot;
- the restore into register 15 on a mode change;
- register 15 holding when the mode is unchanged;
- the priority of a general write to register 15;
- the slots staying stable without a status write;
- read forwarding.

Other properties show only through the bench's scenarios:
- each mode keeps its own stack across several round trips;
- user-mode writes to register 15 never reach the interrupt slot;
- other registers survive swaps;
- after reset the user slot is zero.

// File: rtl/bsp_rf_pkg.sv
package bsp_rf_pkg;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_USR = 1'b1
  } sp_mode_e;

  typedef struct packed {
    logic mode;
    logic ie;
  } st_flags_t;

  localparam int unsigned SP_SLOTS = 2;

endpackage

// File: rtl/bsp_rf_status.sv
module bsp_rf_status
  import bsp_rf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MODE_BIT = 15,
  parameter int unsigned IE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_wr_en,
  input  logic [DATA_W-1:0] st_wr_data,
  output logic              mode_q,
  output logic              ie_q,
  output logic              mode_new,
  output logic              swap
);

  st_flags_t flags_q, flags_d;
  logic      unused_st_bits;

  assign unused_st_bits = ^st_wr_data;

  always_comb begin
    flags_d = flags_q;
    if (st_wr_en) begin
      flags_d.mode = st_wr_data[MODE_BIT];
      flags_d.ie   = st_wr_data[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '{mode: MODE_INT, ie: 1'b0};
    end else if (st_wr_en) begin
      flags_q <= flags_d;
    end
  end

  assign mode_q   = flags_q.mode;
  assign ie_q     = flags_q.ie;
  assign mode_new = flags_d.mode;
  assign swap     = st_wr_en && (flags_d.mode != flags_q.mode);

endmodule

// File: rtl/bsp_rf_sp_bank.sv
module bsp_rf_sp_bank
  import bsp_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       save_en,
  input  logic                       save_sel,
  input  logic [DATA_W-1:0]          save_data,
  input  logic                       restore_sel,
  output logic [DATA_W-1:0]          restore_data,
  output logic [SP_SLOTS*DATA_W-1:0] slots_flat
);

  logic [DATA_W-1:0] slot_q [SP_SLOTS];

  for (genvar s = 0; s < SP_SLOTS; s++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] d;

    always_comb begin
      hit = save_en && (save_sel == s[0]);
      d   = hit ? save_data : slot_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (hit) begin
        slot_q[s] <= d;
      end
    end

    assign slots_flat[s*DATA_W +: DATA_W] = slot_q[s];
  end

  assign restore_data = slot_q[restore_sel];

endmodule

// File: rtl/bsp_rf_core.sv
module bsp_rf_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 16,
  parameter int unsigned SP_IDX = 15,
  localparam int unsigned IW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sp_load_en,
  input  logic [DATA_W-1:0] sp_load_data,
  input  logic [IW-1:0]     rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IW-1:0]     rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] sp_q
);

  logic [DATA_W-1:0] rf_w [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic              wr_hit;
    logic              en;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    if (i == SP_IDX) begin : g_sp
      always_comb begin
        wr_hit = wr_en && (wr_idx == IW'(i));
        en     = wr_hit || sp_load_en;
        d      = wr_hit ? wr_data : sp_load_data;
      end
    end else begin : g_gpr
      always_comb begin
        wr_hit = wr_en && (wr_idx == IW'(i));
        en     = wr_hit;
        d      = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign rf_w[i] = q;
  end

  always_comb begin
    rd_a_data = rf_w[rd_a_idx];
    if (wr_en && (wr_idx == rd_a_idx)) rd_a_data = wr_data;
  end

  always_comb begin
    rd_b_data = rf_w[rd_b_idx];
    if (wr_en && (wr_idx == rd_b_idx)) rd_b_data = wr_data;
  end

  assign sp_q = rf_w[SP_IDX];

endmodule

// File: rtl/bsp_regfile.sv
module bsp_regfile
  import bsp_rf_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NREGS    = 16,
  parameter int unsigned SP_IDX   = 15,
  parameter int unsigned MODE_BIT = 15,
  parameter int unsigned IE_BIT   = 7,
  localparam int unsigned IW      = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IW-1:0]     rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              st_wr_en,
  input  logic [DATA_W-1:0] st_wr_data,
  output logic              stack_mode,
  output logic              int_en
);

  logic                       mode_new;
  logic                       swap;
  logic [DATA_W-1:0]          sp_q;
  logic [DATA_W-1:0]          restore_data;
  logic [SP_SLOTS*DATA_W-1:0] slots_flat;

  bsp_rf_status #(
    .DATA_W  (DATA_W),
    .MODE_BIT(MODE_BIT),
    .IE_BIT  (IE_BIT)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_wr_en  (st_wr_en),
    .st_wr_data(st_wr_data),
    .mode_q    (stack_mode),
    .ie_q      (int_en),
    .mode_new  (mode_new),
    .swap      (swap)
  );

  bsp_rf_sp_bank #(
    .DATA_W(DATA_W)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_en     (st_wr_en),
    .save_sel    (stack_mode),
    .save_data   (sp_q),
    .restore_sel (mode_new),
    .restore_data(restore_data),
    .slots_flat  (slots_flat)
  );

  bsp_rf_core #(
    .DATA_W(DATA_W),
    .NREGS (NREGS),
    .SP_IDX(SP_IDX)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .sp_load_en  (swap),
    .sp_load_data(restore_data),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .sp_q        (sp_q)
  );

endmodule

// File: rtl/bsp_regfile_chk.sv
module bsp_regfile_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NREGS    = 16,
  parameter int unsigned SP_IDX   = 15,
  parameter int unsigned MODE_BIT = 15,
  parameter int unsigned IE_BIT   = 7,
  localparam int unsigned IW      = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IW-1:0]     rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IW-1:0]     rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_wr_en,
  input logic [DATA_W-1:0] st_wr_data,
  input logic              stack_mode,
  input logic              int_en,
  input logic [DATA_W-1:0] sp_q,
  input logic [2*DATA_W-1:0] slots_flat
);

  logic [DATA_W-1:0] slot_int, slot_usr;
  logic              wr_sp;
  logic              new_mode;

  assign slot_int = slots_flat[0 +: DATA_W];
  assign slot_usr = slots_flat[DATA_W +: DATA_W];
  assign wr_sp    = wr_en && (wr_idx == IW'(SP_IDX));
  assign new_mode = st_wr_data[MODE_BIT];

  // R3
  a_r3_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);
  a_r3_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_b_idx == wr_idx) |-> rd_b_data == wr_data);

  // R4
  a_r4_flags_latch: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (stack_mode == $past(st_wr_data[MODE_BIT])) &&
                 (int_en == $past(st_wr_data[IE_BIT])));
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr_en |=> $stable(stack_mode) && $stable(int_en));

  // R5
  a_r5_save_int: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && !stack_mode) |=> slot_int == $past(sp_q));
  a_r5_save_usr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && stack_mode) |=> slot_usr == $past(sp_q));

  // R6
  a_r6_restore_usr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && !stack_mode && new_mode && !wr_sp) |=> sp_q == $past(slot_usr));
  a_r6_restore_int: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && stack_mode && !new_mode && !wr_sp) |=> sp_q == $past(slot_int));

  // R7
  a_r7_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && new_mode == stack_mode && !wr_sp) |=> $stable(sp_q));

  // R8
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && wr_sp) |=> sp_q == $past(wr_data));

  // R9
  a_r9_slots_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr_en |=> $stable(slot_int) && $stable(slot_usr));

endmodule

bind bsp_regfile bsp_regfile_chk #(
  .DATA_W  (DATA_W),
  .NREGS   (NREGS),
  .SP_IDX  (SP_IDX),
  .MODE_BIT(MODE_BIT),
  .IE_BIT  (IE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_b_idx  (rd_b_idx),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .st_wr_en  (st_wr_en),
  .st_wr_data(st_wr_data),
  .stack_mode(stack_mode),
  .int_en    (int_en),
  .sp_q      (sp_q),
  .slots_flat(slots_flat)
);

// File: tb/bsp_regfile_tb.sv
`timescale 1ns/1ps
module bsp_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data, st_wr_data;
  logic        wr_en, st_wr_en, stack_mode, int_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bsp_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .stack_mode(stack_mode), .int_en(int_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] idx, output logic [15:0] val);
    rd_a_idx = idx;
    #0.5;
    val = rd_a_data;
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [15:0] val);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wst(input logic [15:0] val);
    st_wr_en = 1'b1; st_wr_data = val;
    step();
    st_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; st_wr_en = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk("R1 reg clear", v, 16'h0);
    end
    chk("R1 mode", {15'h0, stack_mode}, 16'h0);
    chk("R1 ie", {15'h0, int_en}, 16'h0);
    wreg(4'd15, 16'h9999);
    wst(16'h8000);
    rd(4'd15, v);
    chk("R1 user slot clear", v, 16'h0);
  endtask

  task automatic t_rw();
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 16; i++) wreg(4'(i), 16'(i * 16'h1111 ^ 16'h5A00));
    for (int i = 0; i < 16; i++) begin
      rd_b_idx = 4'(15 - i);
      rd(4'(i), v);
      chk("R2 port A", v, 16'(i * 16'h1111 ^ 16'h5A00));
      chk("R2 port B", rd_b_data, 16'((15 - i) * 16'h1111 ^ 16'h5A00));
    end
  endtask

  task automatic t_bypass();
    do_reset();
    wreg(4'd5, 16'h1234);
    wreg(4'd6, 16'h4321);
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 16'hBEEF;
    rd_a_idx = 4'd5; rd_b_idx = 4'd6;
    #0.5;
    chk("R3 forward A", rd_a_data, 16'hBEEF);
    chk("R3 no forward B", rd_b_data, 16'h4321);
    rd_b_idx = 4'd5;
    #0.5;
    chk("R3 forward B", rd_b_data, 16'hBEEF);
    step();
    wr_en = 1'b0;
    #0.5;
    chk("R3 stored", rd_a_data, 16'hBEEF);
  endtask

  task automatic t_flags();
    do_reset();
    wst(16'h7F80);
    chk("R4 mode0", {15'h0, stack_mode}, 16'h0);
    chk("R4 ie1", {15'h0, int_en}, 16'h1);
    wst(16'h807F);
    chk("R4 mode1", {15'h0, stack_mode}, 16'h1);
    chk("R4 ie0", {15'h0, int_en}, 16'h0);
    step(); step();
    chk("R4 hold mode", {15'h0, stack_mode}, 16'h1);
    chk("R4 hold ie", {15'h0, int_en}, 16'h0);
  endtask

  task automatic t_swap();
    logic [15:0] v;
    do_reset();
    wreg(4'd15, 16'h1111);
    wst(16'h8000);
    rd(4'd15, v);
    chk("R6 enter user", v, 16'h0000);
    wreg(4'd15, 16'h2222);
    wst(16'h0000);
    rd(4'd15, v);
    chk("R5 R6 back to int", v, 16'h1111);
    wst(16'h8080);
    rd(4'd15, v);
    chk("R5 R6 back to user", v, 16'h2222);
    chk("R4 ie after swap", {15'h0, int_en}, 16'h1);
  endtask

  task automatic t_same_mode();
    logic [15:0] v;
    do_reset();
    wreg(4'd15, 16'h3333);
    wst(16'h0080);
    rd(4'd15, v);
    chk("R7 same mode r15", v, 16'h3333);
    wst(16'h8000);
    wreg(4'd15, 16'h6666);
    wst(16'h8000);
    rd(4'd15, v);
    chk("R7 same user mode r15", v, 16'h6666);
    wst(16'h0000);
    rd(4'd15, v);
    chk("R5 int slot kept", v, 16'h3333);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    do_reset();
    wreg(4'd15, 16'h4444);
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 16'h5555;
    wst(16'h8000);
    wr_en = 1'b0;
    rd(4'd15, v);
    chk("R8 write wins", v, 16'h5555);
    wst(16'h0000);
    rd(4'd15, v);
    chk("R8 pre-edge saved", v, 16'h4444);
    wst(16'h8000);
    rd(4'd15, v);
    chk("R8 user slot", v, 16'h5555);
  endtask

  task automatic t_isolation();
    logic [15:0] v;
    do_reset();
    wreg(4'd14, 16'h7777);
    wreg(4'd15, 16'hAAAA);
    wst(16'h8000);
    wreg(4'd15, 16'h1234);
    wreg(4'd15, 16'hBBBB);
    wreg(4'd3, 16'hCCCC);
    wst(16'h0000);
    rd(4'd15, v);
    chk("R9 int slot untouched", v, 16'hAAAA);
    rd(4'd14, v);
    chk("R9 r14 unaffected", v, 16'h7777);
    rd(4'd3, v);
    chk("R9 r3 unaffected", v, 16'hCCCC);
    wst(16'h8000);
    rd(4'd15, v);
    chk("R9 user slot last value", v, 16'hBBBB);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; st_wr_en = 1'b0;
    wr_idx = '0; wr_data = '0; st_wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    t_reset();
    t_rw();
    t_bypass();
    t_flags();
    t_swap();
    t_same_mode();
    t_priority();
    t_isolation();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule